// File: doc/BRIEF.md
# Reversible Linear Congruential Generator

This block produces a 32-bit pseudo-random sequence from a linear congruential recurrence. On every enabled clock the held value is multiplied by a constant and offset by a second constant. Only the low 32 bits of the result are kept. A direction input picks either the forward pair of constants or a second pair that exactly undoes one forward step. The sequence can therefore be walked back to any earlier value, for example to replay a stimulus stream or to rewind a scrambler.

The block works as a small per-cycle operation selector with four named operations:

- HOLD: the value is kept.
- LOAD: a seed is written in.
- FWD: one forward step.
- BWD: one backward step.

The selector takes inputs in this priority order:

- Reset moves the state to the reset seed, whatever the other inputs are.
- Otherwise the load input moves it to LOAD.
- Otherwise, with stepping enabled, the direction input selects FWD or BWD.
- Otherwise the operation is HOLD.

Every operation completes in one clock. The reverse constants are derived from the forward ones when the design is elaborated.

Top module: `rev_lcg`

## Requirements
- R1: While `rst_i` is high at a rising edge, `state_o` becomes 1 after that edge (reset is synchronous and active high).
- R2: With `load_i` low, `step_i` high and `fwd_i` = 1 (FWD), the next `state_o` is (state × 1103515245 + 12345) mod 2^32.
- R3: With `load_i` low, `step_i` high and `fwd_i` = 0 (BWD), the next `state_o` is (state × 4005161829 + 4235699843) mod 2^32.
- R4: A FWD step followed directly by a BWD step returns the value held before the FWD step, and a BWD step followed by a FWD step does the same.
- R5: N consecutive FWD steps followed by N consecutive BWD steps restore the starting value (checked here with N = 5000).
- R6: With `load_i` high (LOAD), the next `state_o` equals `seed_i`, whatever the values of `step_i` and `fwd_i`.
- R7: With `load_i` and `step_i` both low (HOLD), `state_o` does not change, whatever the values of `fwd_i` and `seed_i`.
- R8: The product is truncated to its low 32 bits. From 0xFFFFFFFF a FWD step gives 3191464396, and from 0 a BWD step gives 4235699843.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high; sets the state to 1 |
| step_i | input | 1 | Step enable for FWD or BWD |
| fwd_i | input | 1 | Direction: 1 selects forward, 0 selects backward |
| load_i | input | 1 | Seed load; overrides stepping |
| seed_i | input | 32 | Value written in by LOAD |
| state_o | output | 32 | Current generator state |

## Verification
The hardest situation to reach from the ports is a long forward run that is later unwound exactly. During the run the state visits values far from any seed, and the wraparound of the truncated product must cancel thousands of times. The stimulus loads a random seed, issues five thousand FWD steps and then five thousand BWD steps, and compares the final value with the seed. Constrained random cycles then mix direction flips, idle cycles and loads that collide with step requests, so that the undo pairs and the load priority are hit from many different states.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_FWD  = 2'd2,
        OP_BWD  = 2'd3
    } lcg_op_e;

    // Mask of the low w bits (w up to 64).
    function automatic logic [63:0] low_mask(input int w);
        return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    endfunction

    // Multiplicative inverse of an odd value modulo 2^w by Newton iteration.
    // Each pass doubles the count of correct low bits (3 -> 6 -> ... -> 192).
    function automatic logic [63:0] mod_inverse(input logic [63:0] a, input int w);
        logic [63:0] x;
        x = a;
        for (int i = 0; i < 6; i++) begin
            x = x * (64'd2 - a * x);
        end
        return x & low_mask(w);
    endfunction

    // Addend that cancels the forward offset: -(c * inv) mod 2^w.
    function automatic logic [63:0] undo_addend(input logic [63:0] c,
                                                input logic [63:0] inv,
                                                input int w);
        return (64'd0 - (c * inv)) & low_mask(w);
    endfunction

endpackage

// File: rtl/lcg_op_select.sv
module lcg_op_select
    import lcg_pkg::*;
(
    input  logic    load_i,
    input  logic    step_i,
    input  logic    fwd_i,
    output lcg_op_e op_o
);

    always_comb begin
        if (load_i) begin
            op_o = OP_LOAD;
        end else if (step_i) begin
            op_o = fwd_i ? OP_FWD : OP_BWD;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/lcg_coef_sel.sv
module lcg_coef_sel
    import lcg_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter logic [WIDTH-1:0] MUL_F = WIDTH'(1103515245),
    parameter logic [WIDTH-1:0] ADD_F = WIDTH'(12345),
    parameter logic [WIDTH-1:0] MUL_B = WIDTH'(1),
    parameter logic [WIDTH-1:0] ADD_B = WIDTH'(0)
) (
    input  lcg_op_e          op_i,
    output logic [WIDTH-1:0] mul_o,
    output logic [WIDTH-1:0] add_o
);

    always_comb begin
        unique case (op_i)
            OP_BWD: begin
                mul_o = MUL_B;
                add_o = ADD_B;
            end
            default: begin
                mul_o = MUL_F;
                add_o = ADD_F;
            end
        endcase
    end

endmodule

// File: rtl/lcg_mac.sv
module lcg_mac #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] mul_i,
    input  logic [WIDTH-1:0] add_i,
    output logic [WIDTH-1:0] y_o
);

    // All operands are WIDTH bits wide, so the product keeps only its low word.
    logic [WIDTH-1:0] prod;

    always_comb begin
        prod = x_i * mul_i;
        y_o  = prod + add_i;
    end

endmodule

// File: rtl/rev_lcg.sv
module rev_lcg
    import lcg_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter logic [WIDTH-1:0] MUL_FWD  = WIDTH'(1103515245),
    parameter logic [WIDTH-1:0] ADD_FWD  = WIDTH'(12345),
    parameter logic [WIDTH-1:0] RST_SEED = WIDTH'(1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             step_i,
    input  logic             fwd_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [WIDTH-1:0] MUL_BWD =
        WIDTH'(mod_inverse(64'(MUL_FWD), WIDTH));
    localparam logic [WIDTH-1:0] ADD_BWD =
        WIDTH'(undo_addend(64'(ADD_FWD), 64'(MUL_BWD), WIDTH));

    lcg_op_e          op;
    logic [WIDTH-1:0] mul_sel;
    logic [WIDTH-1:0] add_sel;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    lcg_op_select u_sel (
        .load_i (load_i),
        .step_i (step_i),
        .fwd_i  (fwd_i),
        .op_o   (op)
    );

    lcg_coef_sel #(
        .WIDTH (WIDTH),
        .MUL_F (MUL_FWD),
        .ADD_F (ADD_FWD),
        .MUL_B (MUL_BWD),
        .ADD_B (ADD_BWD)
    ) u_coef (
        .op_i  (op),
        .mul_o (mul_sel),
        .add_o (add_sel)
    );

    lcg_mac #(.WIDTH(WIDTH)) u_mac (
        .x_i   (state_q),
        .mul_i (mul_sel),
        .add_i (add_sel),
        .y_o   (stepped)
    );

    // State register process.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RST_SEED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-value and output process.
    always_comb begin
        unique case (op)
            OP_HOLD: state_d = state_q;
            OP_LOAD: state_d = seed_i;
            OP_FWD:  state_d = stepped;
            OP_BWD:  state_d = stepped;
            default: state_d = state_q;
        endcase
        state_o = state_q;
    end

    assert_reset_seed_R1: assert property (@(posedge clk_i)
        rst_i |=> state_o == RST_SEED);

    assert_fwd_undone_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && fwd_i && !load_i) ##1 (step_i && !fwd_i && !load_i)
        |=> state_o == $past(state_o, 2));

    assert_bwd_undone_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !fwd_i && !load_i) ##1 (step_i && fwd_i && !load_i)
        |=> state_o == $past(state_o, 2));

    assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> state_o == $past(seed_i));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !step_i) |=> $stable(state_o));

endmodule

// File: tb/sim_rev_lcg.sv
module sim_rev_lcg;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        step_i = 1'b0;
    logic        fwd_i = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] seed_i = 32'd0;
    logic [31:0] state_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_v = 32'd1;

    always #10 clk = ~clk;

    rev_lcg u0 (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .step_i  (step_i),
        .fwd_i   (fwd_i),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .state_o (state_o)
    );

    function automatic logic [31:0] fwd_f(input logic [31:0] x);
        logic [63:0] p;
        p = 64'(x) * 64'd1103515245 + 64'd12345;
        return p[31:0];
    endfunction

    function automatic logic [31:0] bwd_f(input logic [31:0] x);
        logic [63:0] p;
        p = 64'(x) * 64'd4005161829 + 64'd4235699843;
        return p[31:0];
    endfunction

    task automatic check(input logic [31:0] want, input string tag);
        checks++;
        if (state_o !== want) begin
            errors++;
            $display("FAIL %s: state_o=%0d expected=%0d", tag, state_o, want);
        end
    endtask

    // Called just after a falling edge; applies one cycle and checks after the rising edge.
    task automatic cyc(input logic s, input logic f, input logic l,
                       input logic [31:0] d, input string tag);
        step_i = s; fwd_i = f; load_i = l; seed_i = d;
        if (l) exp_v = d;
        else if (s) exp_v = f ? fwd_f(exp_v) : bwd_f(exp_v);
        @(posedge clk); #2;
        check(exp_v, tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: state_o=%0d expected=finished", state_o);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] start;
        void'($urandom(32'd4242));
        // R1: reset value, even with a load request present
        load_i = 1'b1; seed_i = 32'hDEADBEEF;
        repeat (3) @(posedge clk);
        #2 check(32'd1, "R1 reset seed");
        @(negedge clk);
        rst_i = 1'b0; load_i = 1'b0;
        exp_v = 32'd1;

        // R2: first forward value from seed 1
        cyc(1, 1, 0, 0, "R2 forward from 1");
        check(32'd1103527590, "R2 literal first value");
        // R3: backward returns to 1
        cyc(1, 0, 0, 0, "R3 backward step");
        check(32'd1, "R4 undo forward");
        // R7: hold with noisy inputs
        cyc(0, 1, 0, 32'h12345678, "R7 hold fwd=1");
        cyc(0, 0, 0, 32'h0BADF00D, "R7 hold fwd=0");
        check(32'd1, "R7 value kept");
        // R6: load beats step in both directions
        cyc(1, 1, 1, 32'hFFFFFFFF, "R6 load over forward");
        // R8: wrap of truncated product
        cyc(1, 1, 0, 0, "R8 forward from all ones");
        check(32'd3191464396, "R8 literal wrap value");
        cyc(1, 0, 1, 32'd0, "R6 load over backward");
        cyc(1, 0, 0, 0, "R8 backward from zero");
        check(32'd4235699843, "R8 literal backward addend");
        cyc(1, 1, 0, 0, "R4 forward undoes backward");
        check(32'd0, "R4 back to zero");

        // R5: long round trip
        start = $urandom;
        cyc(0, 0, 1, start, "R6 load start");
        for (int i = 0; i < 5000; i++) begin
            step_i = 1; fwd_i = 1; load_i = 0;
            exp_v = fwd_f(exp_v);
            @(posedge clk); @(negedge clk);
        end
        check(exp_v, "R2 after long forward run");
        for (int i = 0; i < 5000; i++) begin
            step_i = 1; fwd_i = 0; load_i = 0;
            exp_v = bwd_f(exp_v);
            @(posedge clk); @(negedge clk);
        end
        check(start, "R5 long round trip");

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic rs, rf, rl;
            rs = ($urandom % 4) != 0;
            rf = $urandom % 2;
            rl = ($urandom % 16) == 0;
            cyc(rs, rf, rl, $urandom,
                rl ? "R6 random load" : (!rs ? "R7 random hold" :
                (rf ? "R2 random forward" : "R3 random backward")));
        end

        // Reset mid-run
        rst_i = 1'b1; step_i = 1'b1; fwd_i = 1'b1;
        @(posedge clk); #2;
        check(32'd1, "R1 reset during stepping");
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule